// File: doc/BRIEF.md
# Serial Controller Register Front End

This block is the register front end of a simple asynchronous serial controller. A host reaches it through a single-cycle strobe bus over a 40-byte window of word-aligned offsets. The block holds the controller's configuration registers: frame mode, bit-rate divisor, control, FIFO control and port. A byte written to the transmit data register leaves the block at once as a one-cycle valid/data strobe, ready for a serializer. Five sticky status flags track the transmit side: transmit-end, transmit-data-empty, break, receive-full and data-ready.

A synthesis-time parameter selects between a plain variant and a FIFO variant. In the FIFO variant, masks apply to the mode and control registers, and the status, FIFO control, receive count, port and line status offsets can be reached. In the plain variant those extra offsets do not exist. The receive path lies outside this block. Its byte count comes in on an input port, and nothing here ever sets the break, receive-full or data-ready flags. Firmware clears status flags by writing zeros to their bits.

A status read has a side effect. If transmitting is enabled, both transmit flags are set again after the read, so polling software always sees the transmitter as ready.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the registers hold these values: mode 0x00, bit rate 0xFF, control 0x00, FIFO control 0x00 and port 0x00. The transmit data register holds 0xFF in the plain variant and 0x00 in the FIFO variant. Transmit-end and transmit-data-empty are set and the other three flags are clear. rd_valid, tx_valid and acc_err are low.
- R2: In the FIFO variant, a write to mode (offset 0x00) stores the data ANDed with 0x7B, and a write to control (offset 0x08) stores the data ANDed with 0xFB. The plain variant stores all 8 bits of both.
- R3: A control write whose bit 5 (transmit enable) is 0 sets transmit-end.
- R4: A write to transmit data (offset 0x0C) stores the low byte and drives it on tx_data with tx_valid high for exactly the cycle after the write. It also clears transmit-data-empty.
- R5: In the FIFO variant, a write to status (offset 0x10) clears each flag whose bit is written 0. A flag whose bit is written 1 stays unchanged. The bits are transmit-end at bit 6, transmit-data-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0.
- R6: A status read returns each flag in its R5 bit position, with 0 in every other bit of rd_data.
- R7: If control bit 5 is 1 during a status read, transmit-end and transmit-data-empty are both set after the read. The read itself returns the flag values from before it. If control bit 5 is 0, the read changes no flag.
- R8: In the FIFO variant, reading offset 0x1C returns rx_count zero-extended, and reading offset 0x24 returns 0. Writes to 0x24 and 0x1C have no effect.
- R9: Any of the following accesses is an error: an offset with nonzero low two bits, an offset not in the map (0x14, or 0x28 and above), or offset 0x10, 0x18, 0x1C, 0x20 or 0x24 in the plain variant. An erroneous read returns all ones, an erroneous write changes nothing, and either one raises acc_err for exactly one cycle.
- R10: rd_data and rd_valid are registered. rd_valid is high only in the cycle after an rd_en cycle, and rd_data carries the read value in that cycle.
- R11: Mode (0x00), bit rate (0x04), control (0x08) and transmit data (0x0C) read back their stored values in both variants. FIFO control (0x18) and port (0x20) read back their stored values in the FIFO variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access, never together with wr_en |
| addr | input | ADDR_W (6) | Byte offset into the register window |
| wr_data | input | BUS_W (16) | Write data |
| rd_data | output | BUS_W (16) | Registered read data |
| rd_valid | output | 1 | Read data valid, the cycle after rd_en |
| rx_count | input | CNT_W (8) | Receive byte count from the receive side |
| tx_valid | output | 1 | One-cycle strobe for a transmit byte |
| tx_data | output | DATA_W (8) | Transmit data register, the byte sent |
| acc_err | output | 1 | One-cycle pulse after an erroneous access |

## Verification
On every cycle, the assertions check the following: the flag consequences of single accesses (transmit-end set by a control write with transmit disabled, transmit-data-empty cleared by a data write, written-one flags held, the reload after a status read), the cycle alignment of rd_valid, the all-ones data on an erroneous read, the tie of tx_valid to a write cycle, and the bus rule that a read and a write never coincide. Only the bench's scenarios can show the following: the register masks of each variant, the reset values, the exact status word layout, the ordering within a read (the old flags are returned before the reload), and the difference between the plain and FIFO offset maps. The bench drives both variants side by side with identical bus traffic for this.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
package sercfg_pkg;

  // Status bit positions; firmware decodes these
  localparam int SB_TEND = 6;
  localparam int SB_TDE  = 5;
  localparam int SB_BRK  = 4;
  localparam int SB_RDF  = 1;
  localparam int SB_DR   = 0;

  // Word index (offset / 4) of each register
  localparam int W_MODE  = 0;
  localparam int W_BRATE = 1;
  localparam int W_CTL   = 2;
  localparam int W_TXD   = 3;
  localparam int W_STAT  = 4;
  localparam int W_FCTL  = 6;
  localparam int W_RXCNT = 7;
  localparam int W_PORT  = 8;
  localparam int W_LSTAT = 9;

  // Transmit-enable bit in the control register
  localparam int CTL_TXEN = 5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_BRATE, SEL_CTL, SEL_TXD,
    SEL_STAT, SEL_FCTL, SEL_RXCNT, SEL_PORT, SEL_LSTAT
  } sel_t;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

endpackage

// File: rtl/sercfg_decode.sv
`timescale 1ns/1ps
module sercfg_decode
  import sercfg_pkg::*;
#(
  parameter bit FIFO_EN = 1'b1,
  parameter int ADDR_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic              miss
);

  localparam int WIDX_W = ADDR_W - 2;

  sel_t base_sel;
  sel_t fifo_sel;
  logic [WIDX_W-1:0] widx;

  assign widx = addr[ADDR_W-1:2];

  // Offsets present in both variants
  always_comb begin
    base_sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (int'(widx))
        W_MODE:  base_sel = SEL_MODE;
        W_BRATE: base_sel = SEL_BRATE;
        W_CTL:   base_sel = SEL_CTL;
        W_TXD:   base_sel = SEL_TXD;
        default: base_sel = SEL_NONE;
      endcase
    end
  end

  generate
    if (FIFO_EN) begin : g_fifo_map
      always_comb begin
        fifo_sel = base_sel;
        if (addr[1:0] == 2'b00) begin
          case (int'(widx))
            W_STAT:  fifo_sel = SEL_STAT;
            W_FCTL:  fifo_sel = SEL_FCTL;
            W_RXCNT: fifo_sel = SEL_RXCNT;
            W_PORT:  fifo_sel = SEL_PORT;
            W_LSTAT: fifo_sel = SEL_LSTAT;
            default: fifo_sel = base_sel;
          endcase
        end
      end
    end else begin : g_plain_map
      always_comb fifo_sel = base_sel;
    end
  endgenerate

  assign sel  = fifo_sel;
  assign miss = (fifo_sel == SEL_NONE);

endmodule

// File: rtl/sercfg_flags.sv
`timescale 1ns/1ps
module sercfg_flags
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              ctl_wr_txen,
  input  logic              wr_txd,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] stat_wdata,
  input  logic              rd_stat,
  input  logic              ctl_txen,
  output flags_t            flags
);

  flags_t flags_q;
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (wr_ctl && !ctl_wr_txen) flags_d.tend = 1'b1;
    if (wr_txd) flags_d.tde = 1'b0;
    if (wr_stat) begin
      if (!stat_wdata[SB_TEND]) flags_d.tend = 1'b0;
      if (!stat_wdata[SB_TDE])  flags_d.tde  = 1'b0;
      if (!stat_wdata[SB_BRK])  flags_d.brk  = 1'b0;
      if (!stat_wdata[SB_RDF])  flags_d.rdf  = 1'b0;
      if (!stat_wdata[SB_DR])   flags_d.dr   = 1'b0;
    end
    if (rd_stat && ctl_txen) begin
      flags_d.tend = 1'b1;
      flags_d.tde  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
    else     flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R3
  tend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !ctl_wr_txen) |=> flags_q.tend);

  // R4
  tde_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_txd |=> !flags_q.tde);

  // R5
  keep_on_one_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && stat_wdata[SB_TEND] && stat_wdata[SB_TDE])
      |=> (flags_q.tend == $past(flags_q.tend)) && (flags_q.tde == $past(flags_q.tde)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && ctl_txen) |=> (flags_q.tend && flags_q.tde));

endmodule

// File: rtl/sercfg_txport.sv
`timescale 1ns/1ps
module sercfg_txport #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  RST_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= DATA_W'(RST_BYTE);
    end else begin
      tx_valid <= wr_txd;
      if (wr_txd) tx_data <= wdata;
    end
  end

  // R4
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(wr_txd));

endmodule

// File: rtl/sercfg_rdmux.sv
`timescale 1ns/1ps
module sercfg_rdmux
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 8
) (
  input  sel_t              sel,
  input  logic [DATA_W-1:0] mode_q,
  input  logic [DATA_W-1:0] brate_q,
  input  logic [DATA_W-1:0] ctl_q,
  input  logic [DATA_W-1:0] txd_q,
  input  logic [DATA_W-1:0] fctl_q,
  input  logic [DATA_W-1:0] port_q,
  input  logic [CNT_W-1:0]  rx_count,
  input  flags_t            flags,
  output logic [BUS_W-1:0]  rdata
);

  logic [BUS_W-1:0] stat_word;

  always_comb begin
    stat_word          = '0;
    stat_word[SB_TEND] = flags.tend;
    stat_word[SB_TDE]  = flags.tde;
    stat_word[SB_BRK]  = flags.brk;
    stat_word[SB_RDF]  = flags.rdf;
    stat_word[SB_DR]   = flags.dr;
  end

  always_comb begin
    case (sel)
      SEL_MODE:  rdata = BUS_W'(mode_q);
      SEL_BRATE: rdata = BUS_W'(brate_q);
      SEL_CTL:   rdata = BUS_W'(ctl_q);
      SEL_TXD:   rdata = BUS_W'(txd_q);
      SEL_STAT:  rdata = stat_word;
      SEL_FCTL:  rdata = BUS_W'(fctl_q);
      SEL_RXCNT: rdata = BUS_W'(rx_count);
      SEL_PORT:  rdata = BUS_W'(port_q);
      SEL_LSTAT: rdata = '0;
      default:   rdata = '1;
    endcase
  end

endmodule

// File: rtl/sercfg_regs.sv
`timescale 1ns/1ps
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter bit FIFO_EN = 1'b1,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int BUS_W   = 16,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid,
  input  logic [CNT_W-1:0]  rx_count,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              acc_err
);

  localparam logic [DATA_W-1:0] MODE_MASK = FIFO_EN ? DATA_W'(8'h7B) : '1;
  localparam logic [DATA_W-1:0] CTL_MASK  = FIFO_EN ? DATA_W'(8'hFB) : '1;
  localparam logic [7:0]        TXD_RST   = FIFO_EN ? 8'h00 : 8'hFF;

  sel_t              sel;
  logic              miss;
  logic [DATA_W-1:0] wbyte;
  logic [DATA_W-1:0] mode_q, brate_q, ctl_q, fctl_q, port_q;
  logic [BUS_W-1:0]  rdata_c;
  flags_t            flags;

  assign wbyte = wr_data[DATA_W-1:0];

  sercfg_decode #(.FIFO_EN(FIFO_EN), .ADDR_W(ADDR_W)) decode_i (
    .addr (addr),
    .sel  (sel),
    .miss (miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      brate_q <= '1;
      ctl_q   <= '0;
      fctl_q  <= '0;
      port_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE:  mode_q  <= wbyte & MODE_MASK;
        SEL_BRATE: brate_q <= wbyte;
        SEL_CTL:   ctl_q   <= wbyte & CTL_MASK;
        SEL_FCTL:  fctl_q  <= wbyte;
        SEL_PORT:  port_q  <= wbyte;
        default:   ;
      endcase
    end
  end

  sercfg_flags #(.DATA_W(DATA_W)) flags_i (
    .clk         (clk),
    .rst         (rst),
    .wr_ctl      (wr_en && sel == SEL_CTL),
    .ctl_wr_txen (wbyte[CTL_TXEN]),
    .wr_txd      (wr_en && sel == SEL_TXD),
    .wr_stat     (wr_en && sel == SEL_STAT),
    .stat_wdata  (wbyte),
    .rd_stat     (rd_en && sel == SEL_STAT),
    .ctl_txen    (ctl_q[CTL_TXEN]),
    .flags       (flags)
  );

  sercfg_txport #(.DATA_W(DATA_W), .RST_BYTE(TXD_RST)) txport_i (
    .clk      (clk),
    .rst      (rst),
    .wr_txd   (wr_en && sel == SEL_TXD),
    .wdata    (wbyte),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  sercfg_rdmux #(.DATA_W(DATA_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) rdmux_i (
    .sel      (sel),
    .mode_q   (mode_q),
    .brate_q  (brate_q),
    .ctl_q    (ctl_q),
    .txd_q    (tx_data),
    .fctl_q   (fctl_q),
    .port_q   (port_q),
    .rx_count (rx_count),
    .flags    (flags),
    .rdata    (rdata_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      acc_err  <= (rd_en || wr_en) && miss;
      if (rd_en) rd_data <= rdata_c;
    end
  end

  // R10 (bus rule: one access per cycle)
  no_rdwr_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R9
  err_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && acc_err) |-> (rd_data == '1));

endmodule

// File: tb/sercfg_regs_tb.sv
`timescale 1ns/1ps
module sercfg_regs_tb_top;

  // vector: req[4] wr[1] addr[6] data_or_expf[16] expp[16] errf[1] errp[1]
  localparam int VW = 45;
  localparam int NV = 62;

  function automatic logic [VW-1:0] rv(input int r, input logic [5:0] a,
      input logic [15:0] ef, input logic [15:0] ep, input bit erf, input bit erp);
    return {4'(r), 1'b0, a, ef, ep, erf, erp};
  endfunction

  function automatic logic [VW-1:0] wv(input int r, input logic [5:0] a,
      input logic [15:0] d, input bit erf, input bit erp);
    return {4'(r), 1'b1, a, d, 16'h0000, erf, erp};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    rv(1, 6'h00, 16'h0000, 16'h0000, 0, 0),  // R1
    rv(1, 6'h04, 16'h00FF, 16'h00FF, 0, 0),  // R1
    rv(1, 6'h08, 16'h0000, 16'h0000, 0, 0),  // R1
    rv(1, 6'h0C, 16'h0000, 16'h00FF, 0, 0),  // R1
    rv(6, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R6
    rv(1, 6'h18, 16'h0000, 16'hFFFF, 0, 1),  // R1
    rv(1, 6'h20, 16'h0000, 16'hFFFF, 0, 1),  // R1
    rv(8, 6'h1C, 16'h00A5, 16'hFFFF, 0, 1),  // R8
    rv(8, 6'h24, 16'h0000, 16'hFFFF, 0, 1),  // R8
    rv(9, 6'h14, 16'hFFFF, 16'hFFFF, 1, 1),  // R9
    rv(9, 6'h28, 16'hFFFF, 16'hFFFF, 1, 1),  // R9
    rv(9, 6'h02, 16'hFFFF, 16'hFFFF, 1, 1),  // R9
    rv(9, 6'h3C, 16'hFFFF, 16'hFFFF, 1, 1),  // R9
    wv(2, 6'h00, 16'h00FF, 0, 0),            // R2
    rv(2, 6'h00, 16'h007B, 16'h00FF, 0, 0),  // R2
    wv(2, 6'h08, 16'h00FF, 0, 0),            // R2
    rv(2, 6'h08, 16'h00FB, 16'h00FF, 0, 0),  // R2
    wv(11, 6'h04, 16'h005A, 0, 0),           // R11
    rv(11, 6'h04, 16'h005A, 16'h005A, 0, 0), // R11
    wv(11, 6'h20, 16'h0033, 0, 1),           // R11
    rv(11, 6'h20, 16'h0033, 16'hFFFF, 0, 1), // R11
    wv(11, 6'h18, 16'h000F, 0, 1),           // R11
    rv(11, 6'h18, 16'h000F, 16'hFFFF, 0, 1), // R11
    wv(8, 6'h24, 16'h00AB, 0, 1),            // R8
    rv(8, 6'h24, 16'h0000, 16'hFFFF, 0, 1),  // R8
    wv(8, 6'h1C, 16'h0011, 0, 1),            // R8
    rv(8, 6'h1C, 16'h00A5, 16'hFFFF, 0, 1),  // R8
    wv(9, 6'h14, 16'h0077, 1, 1),            // R9
    rv(9, 6'h00, 16'h007B, 16'h00FF, 0, 0),  // R9
    wv(9, 6'h3C, 16'h0011, 1, 1),            // R9
    rv(9, 6'h04, 16'h005A, 16'h005A, 0, 0),  // R9
    wv(5, 6'h10, 16'h0000, 0, 1),            // R5
    rv(7, 6'h10, 16'h0000, 16'hFFFF, 0, 1),  // R7
    rv(7, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R7
    wv(5, 6'h10, 16'hFFBF, 0, 1),            // R5
    rv(5, 6'h10, 16'h0020, 16'hFFFF, 0, 1),  // R5
    rv(7, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R7
    wv(5, 6'h10, 16'hFFEE, 0, 1),            // R5
    rv(5, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R5
    wv(3, 6'h08, 16'h0000, 0, 0),            // R3
    rv(3, 6'h08, 16'h0000, 16'h0000, 0, 0),  // R3
    wv(5, 6'h10, 16'h0000, 0, 1),            // R5
    rv(5, 6'h10, 16'h0000, 16'hFFFF, 0, 1),  // R5
    rv(7, 6'h10, 16'h0000, 16'hFFFF, 0, 1),  // R7
    wv(3, 6'h08, 16'h0010, 0, 0),            // R3
    rv(3, 6'h10, 16'h0040, 16'hFFFF, 0, 1),  // R3
    rv(3, 6'h08, 16'h0010, 16'h0010, 0, 0),  // R3
    wv(5, 6'h10, 16'hFFDF, 0, 1),            // R5
    rv(5, 6'h10, 16'h0040, 16'hFFFF, 0, 1),  // R5
    wv(2, 6'h08, 16'h0024, 0, 0),            // R2
    rv(2, 6'h08, 16'h0020, 16'h0024, 0, 0),  // R2
    rv(7, 6'h10, 16'h0040, 16'hFFFF, 0, 1),  // R7
    rv(7, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R7
    wv(4, 6'h0C, 16'h00C3, 0, 0),            // R4
    rv(4, 6'h10, 16'h0040, 16'hFFFF, 0, 1),  // R4
    rv(4, 6'h0C, 16'h00C3, 16'h00C3, 0, 0),  // R4
    wv(5, 6'h10, 16'hFFFF, 0, 1),            // R5
    rv(6, 6'h10, 16'h0060, 16'hFFFF, 0, 1),  // R6
    wv(11, 6'h00, 16'h0084, 0, 0),           // R11
    rv(2, 6'h00, 16'h0000, 16'h0084, 0, 0),  // R2
    wv(9, 6'h02, 16'h00FF, 1, 1),            // R9
    rv(9, 6'h00, 16'h0000, 16'h0084, 0, 0)   // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_count = 8'hA5;

  logic [15:0] rd_data_f, rd_data_p;
  logic        rd_valid_f, rd_valid_p, tx_valid_f, tx_valid_p, acc_err_f, acc_err_p;
  logic [7:0]  tx_data_f, tx_data_p;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sercfg_regs #(.FIFO_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data_f), .rd_valid(rd_valid_f),
    .rx_count(rx_count), .tx_valid(tx_valid_f), .tx_data(tx_data_f),
    .acc_err(acc_err_f));

  sercfg_regs #(.FIFO_EN(1'b0)) dut_plain_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data_p), .rd_valid(rd_valid_p),
    .rx_count(rx_count), .tx_valid(tx_valid_p), .tx_data(tx_data_p),
    .acc_err(acc_err_p));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit w, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = w; rd_en = !w; addr = a; wr_data = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: outputs quiet after reset
    chk("R1 rd_valid fifo", 16'(rd_valid_f), 16'h0);
    chk("R1 rd_valid plain", 16'(rd_valid_p), 16'h0);
    chk("R1 tx_valid fifo", 16'(tx_valid_f), 16'h0);
    chk("R1 tx_valid plain", 16'(tx_valid_p), 16'h0);
    chk("R1 acc_err fifo", 16'(acc_err_f), 16'h0);
    chk("R1 acc_err plain", 16'(acc_err_p), 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", int'(v[44:41]), i);
      drive(v[40], v[39:34], v[33:18]);
      if (!v[40]) begin
        chk({tg, " rd_data fifo"}, rd_data_f, v[33:18]);
        chk({tg, " rd_data plain"}, rd_data_p, v[17:2]);
      end
      chk({tg, " rd_valid fifo (R10)"}, 16'(rd_valid_f), 16'(!v[40]));
      chk({tg, " rd_valid plain (R10)"}, 16'(rd_valid_p), 16'(!v[40]));
      chk({tg, " acc_err fifo"}, 16'(acc_err_f), 16'(v[1]));
      chk({tg, " acc_err plain"}, 16'(acc_err_p), 16'(v[0]));
    end
    idle();
    // R10: rd_valid drops after an idle cycle
    chk("R10 rd_valid idle fifo", 16'(rd_valid_f), 16'h0);
    chk("R10 rd_valid idle plain", 16'(rd_valid_p), 16'h0);

    // R4: transmit strobe lasts one cycle
    drive(1'b1, 6'h0C, 16'h0096);
    chk("R4 tx_valid fifo", 16'(tx_valid_f), 16'h1);
    chk("R4 tx_valid plain", 16'(tx_valid_p), 16'h1);
    chk("R4 tx_data fifo", 16'(tx_data_f), 16'h0096);
    chk("R4 tx_data plain", 16'(tx_data_p), 16'h0096);
    idle();
    chk("R4 tx_valid drop fifo", 16'(tx_valid_f), 16'h0);
    chk("R4 tx_valid drop plain", 16'(tx_valid_p), 16'h0);
    chk("R4 tx_data hold fifo", 16'(tx_data_f), 16'h0096);

    // R9: error pulse lasts one cycle
    drive(1'b0, 6'h18, 16'h0000);
    chk("R9 err plain pulse", 16'(acc_err_p), 16'h1);
    chk("R9 no err fifo", 16'(acc_err_f), 16'h0);
    idle();
    chk("R9 err plain drop", 16'(acc_err_p), 16'h0);

    // R1: second reset restores values
    do_reset();
    drive(1'b0, 6'h10, 16'h0000);
    chk("R1 status after reset fifo", rd_data_f, 16'h0060);
    drive(1'b0, 6'h0C, 16'h0000);
    chk("R1 txd after reset fifo", rd_data_f, 16'h0000);
    chk("R1 txd after reset plain", rd_data_p, 16'h00FF);
    drive(1'b0, 6'h04, 16'h0000);
    chk("R1 brate after reset fifo", rd_data_f, 16'h00FF);
    chk("R1 brate after reset plain", rd_data_p, 16'h00FF);
    drive(1'b0, 6'h00, 16'h0000);
    chk("R1 mode after reset plain", rd_data_p, 16'h0000);
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule